// File: doc/BRIEF.md
# DRAM Bank Access Sequencer for an External Bus Master

This block serves DRAM cycles started by a bus master outside the chip. The master drives a full address and raises an address strobe. The block compares that address against a small set of bank windows. Each window has a base, a mask, a valid bit and a burst-enable bit. On a hit, the block runs the row/column timing for the selected bank: it raises that bank's row strobe, then switches an external row/column address multiplexer to the column half, pulses the byte-lane column strobes and returns a one-clock transfer-acknowledge.

The block can also run a line fill, requested with a size code and a transfer-type code. When the bank allows bursts, a line fill becomes four long-word beats under one row strobe. The first beat is a full row+column access and the other three pulse only the column strobes. A two-bit long-word counter drives the DRAM address bits 3:2 during the burst.

All outputs are registered. Timing is set by three parameters: the row-to-column delay, the column pulse width and the row precharge time.

Top module: `dram_xm_seq`

## Requirements
- R1: After reset, and whenever no row strobe is active, `mux_row_sel` is 1 (row half selected). `ras`, `cas` and `xm_ack` are 0 and `burst_lw` is 0 after reset.
- R2: Bank b hits when `bank_valid[b]` is 1 and `(xm_addr & mask_b) == (base_b & mask_b)`. Here `base_b` and `mask_b` are bits `[b*ADDR_W +: ADDR_W]` of `bank_base` and `bank_mask`. An address that hits no bank produces no `ras`, `cas` or `xm_ack`.
- R3: When several banks hit, the lowest-numbered bank is used. `ras[b]` is the row strobe of bank b.
- R4: Timing of a beat. With the strobe sampled high at clock edge E0, `ras` rises after E0 while `mux_row_sel` stays 1. After RCD_CYC more edges, `mux_row_sel` falls and `cas` rises. `cas` stays high for CAS_CYC clocks, then drops, and `xm_ack` is 1 for exactly one clock. At the end of the access, `ras` falls and `mux_row_sel` returns to 1 one clock after that acknowledge.
- R5: On reads (`xm_read`=1), all four `cas` lanes are asserted for every size.
- R6: On writes, `cas[i]` strobes byte offset i. The size codes are:
  - 01 is a byte: only lane `xm_addr[1:0]`.
  - 10 is a word: lanes 3:2 if `xm_addr[1]` is 1, else lanes 1:0.
  - 00 (long word) and 11 (line) select all four lanes.
- R7: A line fill runs as a burst of four beats when all of these hold: `xm_size`=11, `xm_ttype`=FILL_TT, and `bank_burst_en` is set for the selected bank. Between beats `ras` stays asserted and `mux_row_sel` stays 0, `cas` drops for the acknowledge clock, and `xm_ack` pulses once per beat.
- R8: `burst_lw` loads `xm_addr[3:2]` when the cycle starts and increments modulo 4 at the start of each later beat.
- R9: A line-fill size code becomes a single beat when the bank's burst-enable bit is clear or the transfer type differs from FILL_TT.
- R10: If the strobe is sampled low while a cycle is active, the next clock has `ras`=0, `cas`=0, `xm_ack`=0 and `mux_row_sel`=1.
- R11: Once `ras` falls, no row strobe rises for at least PRE_CYC clocks. A new cycle also requires the strobe to have been sampled low after a completed access.
- R12: At most one `ras` bit is active. `cas` is never active unless a `ras` bit is active and `mux_row_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xm_strobe | input | 1 | Master address strobe, high = address valid |
| xm_addr | input | ADDR_W | Master address |
| xm_read | input | 1 | 1 = read, 0 = write |
| xm_size | input | 2 | Size code (00 long, 01 byte, 10 word, 11 line) |
| xm_ttype | input | 2 | Transfer-type code |
| bank_base | input | NUM_BANKS*ADDR_W | Bank base addresses, bank 0 in the low bits |
| bank_mask | input | NUM_BANKS*ADDR_W | Bank compare masks |
| bank_valid | input | NUM_BANKS | Bank enable bits |
| bank_burst_en | input | NUM_BANKS | Bank burst-enable bits |
| mux_row_sel | output | 1 | External mux select, 1 = row half, 0 = column half |
| ras | output | NUM_BANKS | Per-bank row strobes, active high |
| cas | output | 4 | Byte-lane column strobes, active high |
| burst_lw | output | 2 | Long-word address (DRAM address bits 3:2) |
| xm_ack | output | 1 | One-clock transfer-acknowledge |

## Verification
Each result is due a fixed number of edges after the strobe is first sampled at edge E0. With the default parameters:
- `ras` is due after E0.
- `cas`, the falling `mux_row_sel` and `burst_lw` are due after E1.
- `xm_ack` is due after E2.
- Each further burst beat repeats the column/acknowledge pair two edges later.
- Release of `ras` is due one edge after the last acknowledge.

The bench changes inputs and samples outputs only on falling clock edges, and takes one sample between each pair of rising edges. Every check therefore sees the value registered at exactly the edge the count predicts. Abort and precharge cases are driven one half-cycle before the edge that must react, so the absence of a row strobe is observed on the very clock where a faulty design would raise it.

// File: rtl/dram_xm_pkg.sv
package dram_xm_pkg;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_LINE = 2'b11
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RCD,
    ST_CAS,
    ST_ACK
  } seq_state_e;

  typedef struct packed {
    logic [3:0] lanes;
    logic       burst;
    logic [1:0] lw;
  } beat_plan_t;

endpackage

// File: rtl/dram_xm_decode.sv
module dram_xm_decode #(
  parameter int ADDR_W    = 32,
  parameter int NUM_BANKS = 2,
  parameter int IDX_W     = 1
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NUM_BANKS*ADDR_W-1:0] cfg_base,
  input  logic [NUM_BANKS*ADDR_W-1:0] cfg_mask,
  input  logic [NUM_BANKS-1:0]        cfg_valid,
  output logic                        hit,
  output logic [IDX_W-1:0]            idx
);

  logic [NUM_BANKS-1:0] match;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cmp
    logic [ADDR_W-1:0] base_b;
    logic [ADDR_W-1:0] mask_b;
    assign base_b   = cfg_base[b*ADDR_W +: ADDR_W];
    assign mask_b   = cfg_mask[b*ADDR_W +: ADDR_W];
    assign match[b] = cfg_valid[b] && ((addr & mask_b) == (base_b & mask_b));
  end

  // Scan downwards so the lowest matching bank is written last and wins.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (match[b]) begin
        hit = 1'b1;
        idx = IDX_W'(b);
      end
    end
  end

endmodule

// File: rtl/dram_xm_lanes.sv
module dram_xm_lanes
  import dram_xm_pkg::*;
(
  input  logic       rd,
  input  logic [1:0] size,
  input  logic [1:0] low_addr,
  output logic [3:0] lanes
);

  always_comb begin
    if (rd) begin
      lanes = 4'b1111;
    end else begin
      case (xfer_size_e'(size))
        SZ_BYTE: lanes = 4'b0001 << low_addr;
        SZ_WORD: lanes = low_addr[1] ? 4'b1100 : 4'b0011;
        default: lanes = 4'b1111;
      endcase
    end
  end

endmodule

// File: rtl/dram_xm_fsm.sv
module dram_xm_fsm
  import dram_xm_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int IDX_W     = 1,
  parameter int RCD_CYC   = 1,
  parameter int CAS_CYC   = 1,
  parameter int PRE_CYC   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 strobe,
  input  logic                 hit,
  input  logic [IDX_W-1:0]     hit_idx,
  input  beat_plan_t           plan,
  output logic                 mux_row,
  output logic [NUM_BANKS-1:0] ras,
  output logic [3:0]           cas,
  output logic [1:0]           lw,
  output logic                 ack
);

  localparam int CMAX  = (RCD_CYC > CAS_CYC) ? RCD_CYC : CAS_CYC;
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam int PRE_W = $clog2(PRE_CYC + 1);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] pre_cnt;
  logic             need_rel;
  logic [3:0]       lanes_q;
  logic [1:0]       beats_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ras        <= '0;
      cas        <= '0;
      mux_row    <= 1'b1;
      ack        <= 1'b0;
      lw         <= '0;
      cnt        <= '0;
      pre_cnt    <= '0;
      need_rel   <= 1'b0;
      lanes_q    <= '0;
      beats_left <= '0;
    end else begin
      ack <= 1'b0;
      if (!strobe) need_rel <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (pre_cnt != '0) pre_cnt <= pre_cnt - 1'b1;
          if (strobe && hit && (pre_cnt == '0) && !need_rel) begin
            ras        <= NUM_BANKS'(1) << hit_idx;
            lanes_q    <= plan.lanes;
            beats_left <= plan.burst ? 2'd3 : 2'd0;
            lw         <= plan.lw;
            cnt        <= CNT_W'(RCD_CYC - 1);
            state      <= ST_RCD;
          end
        end
        ST_RCD: begin
          if (!strobe) begin
            ras     <= '0;
            cas     <= '0;
            mux_row <= 1'b1;
            pre_cnt <= PRE_W'(PRE_CYC - 1);
            state   <= ST_IDLE;
          end else if (cnt == '0) begin
            mux_row <= 1'b0;
            cas     <= lanes_q;
            cnt     <= CNT_W'(CAS_CYC - 1);
            state   <= ST_CAS;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_CAS: begin
          if (!strobe) begin
            ras     <= '0;
            cas     <= '0;
            mux_row <= 1'b1;
            pre_cnt <= PRE_W'(PRE_CYC - 1);
            state   <= ST_IDLE;
          end else if (cnt == '0) begin
            cas   <= '0;
            ack   <= 1'b1;
            state <= ST_ACK;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_ACK: begin
          if (!strobe || beats_left == 2'd0) begin
            ras      <= '0;
            mux_row  <= 1'b1;
            pre_cnt  <= PRE_W'(PRE_CYC - 1);
            need_rel <= strobe;
            state    <= ST_IDLE;
          end else begin
            cas        <= lanes_q;
            lw         <= lw + 2'd1;
            beats_left <= beats_left - 2'd1;
            cnt        <= CNT_W'(CAS_CYC - 1);
            state      <= ST_CAS;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dram_xm_seq.sv
module dram_xm_seq
  import dram_xm_pkg::*;
#(
  parameter int         ADDR_W    = 32,
  parameter int         NUM_BANKS = 2,
  parameter int         RCD_CYC   = 1,
  parameter int         CAS_CYC   = 1,
  parameter int         PRE_CYC   = 2,
  parameter logic [1:0] FILL_TT   = 2'b00
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        xm_strobe,
  input  logic [ADDR_W-1:0]           xm_addr,
  input  logic                        xm_read,
  input  logic [1:0]                  xm_size,
  input  logic [1:0]                  xm_ttype,
  input  logic [NUM_BANKS*ADDR_W-1:0] bank_base,
  input  logic [NUM_BANKS*ADDR_W-1:0] bank_mask,
  input  logic [NUM_BANKS-1:0]        bank_valid,
  input  logic [NUM_BANKS-1:0]        bank_burst_en,
  output logic                        mux_row_sel,
  output logic [NUM_BANKS-1:0]        ras,
  output logic [3:0]                  cas,
  output logic [1:0]                  burst_lw,
  output logic                        xm_ack
);

  localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic [3:0]       lanes;
  beat_plan_t       plan;

  dram_xm_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_BANKS(NUM_BANKS),
    .IDX_W    (IDX_W)
  ) i_decode (
    .addr     (xm_addr),
    .cfg_base (bank_base),
    .cfg_mask (bank_mask),
    .cfg_valid(bank_valid),
    .hit      (hit),
    .idx      (hit_idx)
  );

  dram_xm_lanes i_lanes (
    .rd      (xm_read),
    .size    (xm_size),
    .low_addr(xm_addr[1:0]),
    .lanes   (lanes)
  );

  always_comb begin
    plan.lanes = lanes;
    plan.burst = (xm_size == SZ_LINE) && (xm_ttype == FILL_TT) && bank_burst_en[hit_idx];
    plan.lw    = xm_addr[3:2];
  end

  dram_xm_fsm #(
    .NUM_BANKS(NUM_BANKS),
    .IDX_W    (IDX_W),
    .RCD_CYC  (RCD_CYC),
    .CAS_CYC  (CAS_CYC),
    .PRE_CYC  (PRE_CYC)
  ) i_fsm (
    .clk    (clk),
    .rst    (rst),
    .strobe (xm_strobe),
    .hit    (hit),
    .hit_idx(hit_idx),
    .plan   (plan),
    .mux_row(mux_row_sel),
    .ras    (ras),
    .cas    (cas),
    .lw     (burst_lw),
    .ack    (xm_ack)
  );

endmodule

// File: rtl/dram_xm_chk.sv
module dram_xm_chk #(
  parameter int NUM_BANKS = 2,
  parameter int PRE_CYC   = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 xm_strobe,
  input logic                 mux_row_sel,
  input logic [NUM_BANKS-1:0] ras,
  input logic [3:0]           cas,
  input logic [1:0]           burst_lw,
  input logic                 xm_ack
);

  localparam int LC_W = $clog2(PRE_CYC + 1);

  logic [LC_W-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) low_cnt <= LC_W'(PRE_CYC);
    else if (|ras) low_cnt <= '0;
    else if (low_cnt < LC_W'(PRE_CYC)) low_cnt <= low_cnt + 1'b1;
  end

  p_row_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !(|ras) |-> mux_row_sel);

  p_ack_single_r4: assert property (@(posedge clk) disable iff (rst)
    xm_ack |=> !xm_ack);

  p_lw_step_r8: assert property (@(posedge clk) disable iff (rst)
    ((|cas) && !$past(|cas) && $past(xm_ack)) |-> (burst_lw == $past(burst_lw) + 2'd1));

  p_abort_r10: assert property (@(posedge clk) disable iff (rst)
    !xm_strobe |=> (!(|ras) && !(|cas) && !xm_ack && mux_row_sel));

  p_precharge_r11: assert property (@(posedge clk) disable iff (rst)
    ((|ras) && !$past(|ras)) |-> (low_cnt >= LC_W'(PRE_CYC)));

  p_ras_onehot_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ras));

  p_cas_guard_r12: assert property (@(posedge clk) disable iff (rst)
    (|cas) |-> ((|ras) && !mux_row_sel));

endmodule

bind dram_xm_seq dram_xm_chk #(
  .NUM_BANKS(NUM_BANKS),
  .PRE_CYC  (PRE_CYC)
) i_chk (
  .clk        (clk),
  .rst        (rst),
  .xm_strobe  (xm_strobe),
  .mux_row_sel(mux_row_sel),
  .ras        (ras),
  .cas        (cas),
  .burst_lw   (burst_lw),
  .xm_ack     (xm_ack)
);

// File: tb/test_dram_xm_seq.sv
module test_dram_xm_seq;

  localparam int NB = 2;
  localparam int AW = 32;
  localparam int NV = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          xm_strobe = 1'b0;
  logic [AW-1:0] xm_addr = '0;
  logic          xm_read = 1'b0;
  logic [1:0]    xm_size = 2'b00;
  logic [1:0]    xm_ttype = 2'b00;
  logic [NB*AW-1:0] bank_base;
  logic [NB*AW-1:0] bank_mask;
  logic [NB-1:0] bank_valid;
  logic [NB-1:0] bank_burst_en;
  logic          mux_row_sel;
  logic [NB-1:0] ras;
  logic [3:0]    cas;
  logic [1:0]    burst_lw;
  logic          xm_ack;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dram_xm_seq i_dram_xm_seq (
    .clk(clk), .rst(rst), .xm_strobe(xm_strobe), .xm_addr(xm_addr),
    .xm_read(xm_read), .xm_size(xm_size), .xm_ttype(xm_ttype),
    .bank_base(bank_base), .bank_mask(bank_mask), .bank_valid(bank_valid),
    .bank_burst_en(bank_burst_en), .mux_row_sel(mux_row_sel), .ras(ras),
    .cas(cas), .burst_lw(burst_lw), .xm_ack(xm_ack)
  );

  // {addr, read, size, ttype, bank (3 = miss), lanes, beats}
  localparam logic [45:0] VEC [NV] = '{
    {32'h0000_0010, 1'b1, 2'b00, 2'b00, 2'd0, 4'b1111, 3'd1},
    {32'h0000_0021, 1'b1, 2'b01, 2'b00, 2'd0, 4'b1111, 3'd1},
    {32'h0001_0002, 1'b0, 2'b01, 2'b00, 2'd1, 4'b0100, 3'd1},
    {32'h0001_0003, 1'b0, 2'b01, 2'b00, 2'd1, 4'b1000, 3'd1},
    {32'h0001_0002, 1'b0, 2'b10, 2'b00, 2'd1, 4'b1100, 3'd1},
    {32'h0001_0000, 1'b0, 2'b10, 2'b00, 2'd1, 4'b0011, 3'd1},
    {32'h0001_0004, 1'b0, 2'b00, 2'b00, 2'd1, 4'b1111, 3'd1},
    {32'h0001_0008, 1'b1, 2'b11, 2'b00, 2'd1, 4'b1111, 3'd4},
    {32'h0001_000C, 1'b0, 2'b11, 2'b00, 2'd1, 4'b1111, 3'd4},
    {32'h0000_0000, 1'b1, 2'b11, 2'b00, 2'd0, 4'b1111, 3'd1},
    {32'h0001_0004, 1'b1, 2'b11, 2'b01, 2'd1, 4'b1111, 3'd1},
    {32'h0100_0000, 1'b1, 2'b00, 2'b00, 2'd3, 4'b0000, 3'd0},
    {32'h0000_0005, 1'b0, 2'b01, 2'b00, 2'd0, 4'b0010, 3'd1}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic rd, input logic [1:0] sz,
                        input logic [1:0] tt, input int bank, input logic [3:0] lanes,
                        input int beats);
    string tag_l = rd ? "R5" : "R6";
    string tag_b = (beats > 1) ? "R7" : ((sz == 2'b11) ? "R9" : "R4");
    string tag_r = (a[31:16] == 16'h0000) ? "R3" : "R2";
    logic [NB-1:0] exp_ras;
    @(negedge clk);
    xm_addr = a; xm_read = rd; xm_size = sz; xm_ttype = tt; xm_strobe = 1'b1;
    @(negedge clk);
    if (beats == 0) begin
      for (int i = 0; i < 3; i++) begin
        chk("R2", "miss ras", 32'(ras), 0);
        chk("R2", "miss ack", 32'(xm_ack), 0);
        @(negedge clk);
      end
      xm_strobe = 1'b0;
      @(negedge clk);
      return;
    end
    exp_ras = NB'(1) << bank;
    chk(tag_r, "ras on", 32'(ras), 32'(exp_ras));
    chk("R4", "mux row during rcd", 32'(mux_row_sel), 1);
    chk("R4", "cas off during rcd", 32'(cas), 0);
    for (int k = 0; k < beats; k++) begin
      @(negedge clk);
      chk(tag_l, "cas lanes", 32'(cas), 32'(lanes));
      chk("R12", "mux col with cas", 32'(mux_row_sel), 0);
      chk(tag_b, "ras held", 32'(ras), 32'(exp_ras));
      chk("R8", "burst_lw", 32'(burst_lw), 32'(2'(a[3:2] + k)));
      @(negedge clk);
      chk(tag_b, "ack beat", 32'(xm_ack), 1);
      chk(tag_b, "cas off at ack", 32'(cas), 0);
    end
    @(negedge clk);
    chk(tag_b, "extra ack", 32'(xm_ack), 0);
    chk("R4", "ras off at end", 32'(ras), 0);
    chk("R1", "mux row at end", 32'(mux_row_sel), 1);
    xm_strobe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bank_base     = {32'h0000_0000, 32'h0000_0000};
    bank_mask     = {32'hFFF0_0000, 32'hFFFF_0000};
    bank_valid    = 2'b11;
    bank_burst_en = 2'b10;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset mux", 32'(mux_row_sel), 1);
    chk("R1", "reset ras", 32'(ras), 0);
    chk("R1", "reset cas", 32'(cas), 0);
    chk("R1", "reset ack", 32'(xm_ack), 0);
    chk("R1", "reset burst_lw", 32'(burst_lw), 0);

    for (int v = 0; v < NV; v++) begin
      access(VEC[v][45:14], VEC[v][13], VEC[v][12:11], VEC[v][10:9],
             int'(VEC[v][8:7]), VEC[v][6:3], int'(VEC[v][2:0]));
    end

    // R2 / R3: bank 0 invalid, so bank 1 takes its region; none valid -> miss
    bank_valid = 2'b10;
    access(32'h0000_0010, 1'b1, 2'b00, 2'b00, 1, 4'b1111, 1);
    bank_valid = 2'b00;
    access(32'h0001_0000, 1'b1, 2'b00, 2'b00, 3, 4'b0000, 0);
    bank_valid = 2'b11;

    // R10: strobe dropped while the column strobe is active
    @(negedge clk);
    xm_addr = 32'h0001_0000; xm_read = 1'b1; xm_size = 2'b00; xm_strobe = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10", "cas before abort", 32'(cas), 32'hF);
    xm_strobe = 1'b0;
    @(negedge clk);
    chk("R10", "ras after abort", 32'(ras), 0);
    chk("R10", "cas after abort", 32'(cas), 0);
    chk("R10", "mux after abort", 32'(mux_row_sel), 1);
    chk("R10", "ack after abort", 32'(xm_ack), 0);
    repeat (2) @(negedge clk);

    // R11: strobe held high after completion must not start another cycle
    @(negedge clk);
    xm_strobe = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "ras off after held access", 32'(ras), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11", "no restart without release", 32'(ras), 0);
    end
    xm_strobe = 1'b0;
    repeat (2) @(negedge clk);

    // R11: abort, then immediate re-strobe waits out precharge
    @(negedge clk);
    xm_strobe = 1'b1;
    @(negedge clk);
    chk("R11", "ras on before abort", 32'(ras), 32'h2);
    xm_strobe = 1'b0;
    @(negedge clk);
    chk("R10", "ras off after rcd abort", 32'(ras), 0);
    xm_strobe = 1'b1;
    @(negedge clk);
    chk("R11", "ras held off in precharge", 32'(ras), 0);
    @(negedge clk);
    chk("R11", "ras on after precharge", 32'(ras), 32'h2);
    xm_strobe = 1'b0;
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule